// File: doc/BRIEF.md
# QRSS Test Pattern Detector

This block watches a received unipolar bit stream and decides whether it carries the quasi-random test signal. That signal is the 2^20-1 sequence from x^20 + x^17 + 1, with any raw bit forced to one when the 14 raw bits after it are all zero, so the line never sees more than 14 zeros in a row. The block reports its result on one status line. The line is held high while the pattern is not recognised. It falls low once the detector has locked. While locked, it rises for half a clock period for every received bit that disagrees with the reference. An external error counter can count those pulses directly.

Acquisition seeds a 20-stage reference register from the received bits. It declares lock after a run of correct predictions. After lock the reference free-runs and no longer looks at the line. Too many errors inside one counting window drop lock and start acquisition again. A loss-of-signal flag and a mode enable both override the status line and force it high.

Top module: `qrss_detector`

## Requirements
- R1: After reset the detector is unlocked and `status` is high.
- R2: The reference bit for a received bit is raw bit r[n] = r[n-20] xor r[n-17], or'ed with one when the next 14 raw bits are all zero. Lock is declared on the 32nd consecutive correct prediction, so `status` stays high for at least the first 31 accepted bits and then goes low.
- R3: A constant all-zero or all-one input never produces lock.
- R4: While locked, a mismatching bit drives `status` high from the rising edge that accepts the bit until the following falling edge. Two errors in consecutive bits give two separate pulses.
- R5: Accepted bits are grouped into windows of 64, counted from the moment of lock. Fewer than 8 errors in every window keeps lock. The 8th error inside a window drops lock, `status` then stays high until the pattern is acquired again.
- R6: Clock cycles with `bit_en` low change nothing: no pulse, no lock change, and no step of the reference.
- R7: `los` high forces `status` high whatever the lock state. `los` alone does not clear lock, so `status` returns low when `los` falls.
- R8: With `qrss_en` low, `status` is high and lock is cleared. After re-enabling, the detector must acquire the pattern again.
- R9: Once locked, the reference advances on its own. Corrupted input bits therefore leave later clean bits matching, with no further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bits are accepted on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks the cycle's `bit_in` as a valid received bit |
| bit_in | input | 1 | Received unipolar data bit |
| qrss_en | input | 1 | Enables detection; low holds the detector idle |
| los | input | 1 | Loss-of-signal level from the receiver |
| status | output | 1 | High: not locked, error pulse, or override; low: locked and clean |

## Verification
Four kinds of input are used. A clean pattern stream shows that lock arrives no earlier than 32 bits and within a bounded time. Single, paired, seven-fold and sixteen-fold bit inversions tell an isolated half-cycle pulse apart from merged pulses, and separate tolerated error bursts from ones that drop lock. Constant zero and constant one inputs show that degenerate streams which a naive predictor would follow cannot fake lock. Idle strobe gaps with toggling data, loss-of-signal, and mode toggling show that each override or gap affects only the level it should.

// File: rtl/qrss_detector.sv
module qrss_detector #(
  parameter int PRBS_LEN  = 20,
  parameter int TAP       = 17,
  parameter int ZERO_LIM  = 14,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic qrss_en,
  input  logic los,
  output logic status
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int ERR_W = $clog2(ERR_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [ERR_W-1:0] ERR_MAX  = ERR_W'(ERR_LIMIT);

  logic [PRBS_LEN-1:0] ref_q;
  logic [ZERO_LIM:0]   ahead;
  logic [RUN_W-1:0]    run_q;
  logic [WIN_W-1:0]    win_q;
  logic [ERR_W-1:0]    errs_q;
  logic [ERR_W-1:0]    err_sum;
  logic                locked_r;
  logic                err_tgl_r;
  logic                err_tgl_n;
  logic                predict;
  logic                miss;
  logic                seed_ok;

  // ahead[i] is the raw bit i+1 steps beyond the newest one held in ref_q
  for (genvar i = 0; i <= ZERO_LIM; i++) begin : g_ahead
    assign ahead[i] = ref_q[PRBS_LEN-1-i] ^ ref_q[TAP-1-i];
  end

  assign predict = ahead[0] | ~|ahead[ZERO_LIM:1];
  assign miss    = bit_in ^ predict;
  assign seed_ok = |ref_q;
  assign err_sum = errs_q + ERR_W'(miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= '0;
      run_q     <= '0;
      win_q     <= '0;
      errs_q    <= '0;
      locked_r  <= 1'b0;
      err_tgl_r <= 1'b0;
    end else if (!qrss_en) begin
      ref_q    <= '0;
      run_q    <= '0;
      win_q    <= '0;
      errs_q   <= '0;
      locked_r <= 1'b0;
    end else if (bit_en) begin
      if (locked_r) begin
        ref_q <= {ref_q[PRBS_LEN-2:0], ahead[0]};
        if (miss) err_tgl_r <= ~err_tgl_r;
        if (err_sum >= ERR_MAX) begin
          locked_r <= 1'b0;
          run_q    <= '0;
          win_q    <= '0;
          errs_q   <= '0;
        end else if (win_q == WIN_LAST) begin
          win_q  <= '0;
          errs_q <= '0;
        end else begin
          win_q  <= win_q + 1'b1;
          errs_q <= err_sum;
        end
      end else if (seed_ok && !miss) begin
        ref_q <= {ref_q[PRBS_LEN-2:0], ahead[0]};
        if (run_q == RUN_LAST) begin
          locked_r <= 1'b1;
          run_q    <= '0;
          win_q    <= '0;
          errs_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        ref_q <= {ref_q[PRBS_LEN-2:0], bit_in};
        run_q <= '0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) err_tgl_n <= 1'b0;
    else        err_tgl_n <= err_tgl_r;
  end

  assign status = ~qrss_en | los | ~locked_r | (err_tgl_r ^ err_tgl_n);

endmodule

// File: rtl/qrss_detector_chk.sv
module qrss_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic qrss_en,
  input logic los,
  input logic status,
  input logic locked,
  input logic err_tgl
);

  a_r1_unlocked_high: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> status);

  a_r7_los_high: assert property (@(posedge clk) disable iff (!rst_n)
    los |-> status);

  a_r8_mode_off_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    !qrss_en |=> !locked);

  a_r6_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (qrss_en && !bit_en) |=> ($stable(locked) && $stable(err_tgl)));

  a_r4_pulse_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tgl != $past(err_tgl)) |-> $past(locked));

  a_r2_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(bit_en) && $past(qrss_en)));

  a_r5_drop_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(bit_en) || !$past(qrss_en)));

endmodule

bind qrss_detector qrss_detector_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .qrss_en (qrss_en),
  .los     (los),
  .status  (status),
  .locked  (locked_r),
  .err_tgl (err_tgl_r)
);

// File: tb/test_qrss_detector.sv
`timescale 1ns/1ps
module test_qrss_detector;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic qrss_en = 1'b0;
  logic los = 1'b0;
  logic status;

  int n_chk = 0;
  int n_bad = 0;
  int pos = 0;
  logic hi_s, lo_s;
  bit done = 1'b0;

  localparam int NBITS = 4096;
  bit raw [0:NBITS+15];
  bit pat [0:NBITS-1];

  always #2.5 clk = ~clk;

  qrss_detector i_qrss_detector (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .qrss_en(qrss_en), .los(los), .status(status)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns samples from both clock halves
  task automatic do_step(input logic b, input logic en);
    bit_in = b;
    bit_en = en;
    @(posedge clk); #1 hi_s = status;
    @(negedge clk); #1 lo_s = status;
  endtask

  task automatic feed_clean(input int n, output logic any_high);
    any_high = 1'b0;
    for (int i = 0; i < n; i++) begin
      do_step(pat[pos], 1'b1);
      pos++;
      if (hi_s !== 1'b0 || lo_s !== 1'b0) any_high = 1'b1;
    end
  endtask

  task automatic wait_lock(input int limit, input string tag);
    logic got = 1'b0;
    for (int i = 0; i < limit && !got; i++) begin
      do_step(pat[pos], 1'b1);
      pos++;
      if (lo_s === 1'b0) got = 1'b1;
    end
    check(got, 1'b1, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    bit_en = 1'b0;
    qrss_en = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #1 check(status, 1'b1, "R1 reset state high");
  endtask

  task automatic t_mode_off();
    logic low_seen = 1'b0;
    qrss_en = 1'b0;
    for (int i = 0; i < 100; i++) begin
      do_step(pat[pos], 1'b1);
      pos++;
      if (hi_s !== 1'b1 || lo_s !== 1'b1) low_seen = 1'b1;
    end
    check(low_seen, 1'b0, "R8 disabled mode holds high");
    qrss_en = 1'b1;
  endtask

  task automatic t_acquire();
    logic bad;
    logic early = 1'b0;
    for (int i = 0; i < 31; i++) begin
      do_step(pat[pos], 1'b1);
      pos++;
      if (lo_s !== 1'b1) early = 1'b1;
    end
    check(early, 1'b0, "R2 no lock within 31 bits");
    wait_lock(150, "R2 lock acquired");
    feed_clean(300, bad);
    check(bad, 1'b0, "R2 lock held on clean stream");
  endtask

  task automatic t_single_err();
    logic bad;
    do_step(~pat[pos], 1'b1);
    pos++;
    check(hi_s, 1'b1, "R4 single error first half");
    check(lo_s, 1'b0, "R4 single error cleared at falling edge");
    feed_clean(70, bad);
    check(bad, 1'b0, "R9 clean bits after error still match");
  endtask

  task automatic t_double_err();
    logic bad;
    for (int k = 0; k < 2; k++) begin
      do_step(~pat[pos], 1'b1);
      pos++;
      check(hi_s, 1'b1, "R4 back-to-back error pulse high");
      check(lo_s, 1'b0, "R4 back-to-back error pulse low");
    end
    feed_clean(70, bad);
    check(bad, 1'b0, "R9 free-run after two errors");
  endtask

  task automatic t_seven_err();
    logic bad;
    logic miss_pulse = 1'b0;
    for (int k = 0; k < 7; k++) begin
      do_step(~pat[pos], 1'b1);
      pos++;
      if (hi_s !== 1'b1 || lo_s !== 1'b0) miss_pulse = 1'b1;
    end
    check(miss_pulse, 1'b0, "R4 seven pulses");
    feed_clean(100, bad);
    check(bad, 1'b0, "R5 seven errors keep lock");
  endtask

  task automatic t_sixteen_err();
    for (int k = 0; k < 16; k++) begin
      do_step(~pat[pos], 1'b1);
      pos++;
    end
    do_step(pat[pos], 1'b1);
    pos++;
    check(lo_s, 1'b1, "R5 burst drops lock");
    wait_lock(150, "R5 reacquire after drop");
  endtask

  task automatic t_los();
    logic bad;
    logic not_high = 1'b0;
    los = 1'b1;
    for (int i = 0; i < 5; i++) begin
      do_step(pat[pos], 1'b1);
      pos++;
      if (hi_s !== 1'b1 || lo_s !== 1'b1) not_high = 1'b1;
    end
    check(not_high, 1'b0, "R7 los forces high");
    los = 1'b0;
    feed_clean(5, bad);
    check(bad, 1'b0, "R7 lock kept through los");
  endtask

  task automatic t_idle();
    logic bad;
    logic idle_bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      do_step(i[0], 1'b0);
      if (hi_s !== 1'b0 || lo_s !== 1'b0) idle_bad = 1'b1;
    end
    check(idle_bad, 1'b0, "R6 idle cycles give no pulse");
    feed_clean(30, bad);
    check(bad, 1'b0, "R6 reference did not step while idle");
  endtask

  task automatic t_reenable();
    logic early = 1'b0;
    qrss_en = 1'b0;
    do_step(1'b0, 1'b0);
    check(lo_s, 1'b1, "R8 disable forces high");
    qrss_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      do_step(pat[pos], 1'b1);
      pos++;
      if (lo_s !== 1'b1) early = 1'b1;
    end
    check(early, 1'b0, "R8 lock cleared by disable");
    wait_lock(150, "R8 reacquire after enable");
  endtask

  task automatic t_constant(input logic v, input string tag);
    logic low_seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      do_step(v, 1'b1);
      if (lo_s !== 1'b1) low_seen = 1'b1;
    end
    check(low_seen, 1'b0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] seed = 20'hA5C3F;
    for (int i = 0; i < 20; i++) raw[i] = seed[i];
    for (int i = 20; i < NBITS + 16; i++) raw[i] = raw[i-20] ^ raw[i-17];
    for (int i = 0; i < NBITS; i++) begin
      bit z = 1'b1;
      for (int j = 1; j <= 14; j++) if (raw[i+j]) z = 1'b0;
      pat[i] = raw[i] | z;
    end

    @(negedge clk);
    t_reset();
    t_mode_off();
    t_acquire();
    t_single_err();
    t_double_err();
    t_seven_err();
    t_sixteen_err();
    t_los();
    t_idle();
    t_reenable();
    t_reset();
    t_constant(1'b0, "R3 all zeros never lock");
    t_reset();
    t_constant(1'b1, "R3 all ones never lock");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule